// File: doc/BRIEF.md
# MDIO Link and Media Sense Sequencer

After reset this block talks to an attached Ethernet PHY over a two-wire management bus and settles the MAC's operating mode on its own, with no software involved. It contains a management-frame engine that serialises read and write frames on MDC/MDIO, a divider that paces MDC, a poll timer, and a sequencer that walks the decision flow. In normal operation it keeps reading the PHY basic status register until link and auto-negotiation completion are both reported. It then reads a vendor status register to choose full or half duplex. If the timer runs out first, it selects an alternate home-network PHY path and programs that PHY according to the PHY's identity and revision. A strap input marks a device variant that skips sensing and forces the PHY into 10 Mb/s operation.

The sequencer and the frame engine exchange commands over a valid/ready channel. The sequencer holds a command stable until the engine is idle and accepts it. The engine returns one single-cycle response pulse per frame, and the sequencer never issues a new command before that pulse. The block has no handshake at its edge. The mode outputs and `done` are plain levels. `store_fwd` goes high right after reset.

Top module: `media_sense_seq`

## Requirements
- R1: While reset is held, `store_fwd`, `full_duplex`, `alt_path` and `done` are 0. From the first clock after reset `store_fwd` is 1, and it then stays 1.
- R2: Every frame is sent MSB first and consists of 34 ones, start bits 0 then 1, an opcode (1,0 for read; 0,1 for write), PHY address 1 in 5 bits, and a 5-bit register number. MDIO changes only while MDC is low, and the PHY samples it on the rising MDC edge.
- R3: Each MDC high phase and each low phase inside a frame lasts exactly `HALF_CLKS` system clocks. MDC rests low between frames.
- R4: A read frame releases `mdio_oe` for one turnaround slot and 16 data slots. It captures `mdio_i` at the 16 rising MDC edges, MSB first.
- R5: A write frame keeps `mdio_oe` high and drives 1 then 0 as turnaround, followed by the 16 data bits MSB first.
- R6: Register 1 is read again and again until one read shows both bit 5 and bit 2 set (mask 0x0024). A read that shows only one of these bits does not end the polling.
- R7: Once link is seen, register 17 is read. `full_duplex` becomes 1 when that value ANDed with 0xA000 is nonzero and 0 otherwise, and `alt_path` stays 0.
- R8: If `POLL_CLKS` clocks of polling pass without link, the read that is in progress completes, and then `alt_path` becomes 1 and `full_duplex` stays 0. These two bits are never 1 together.
- R9: On the alternate path register 3 is read. If that value ANDed with 0xFFF0 is not 0xB900, no PHY register is written and the sequence ends.
- R10: If the ID matches and register 31 reads 0x4404, register 16 is written with 0x0005 when the ID equals 0xB901 and with 0x1005 otherwise. Register 24 is then read, and register 25 is written with ((value+3) & 0x00FF) | 0xF000.
- R11: If the ID matches and register 31 reads anything other than 0x4404, register 16 is written with 0x0005. Register 25 is then read and written back as (value & 0xFF00) + 2.
- R12: With `fixed_10m` high through reset, nothing is read. Register 0 is written with 0x0000, and both `full_duplex` and `alt_path` stay 0.
- R13: `done` rises once the sequence ends and stays high until reset. While it is high no frame starts and `full_duplex` and `alt_path` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; releasing it starts the sequence |
| fixed_10m | input | 1 | Device-variant strap: force 10 Mb/s, skip sensing |
| mdio_i | input | 1 | Management data from the PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data to the PHY |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| store_fwd | output | 1 | Store-and-forward mode bit |
| full_duplex | output | 1 | Full-duplex mode bit |
| alt_path | output | 1 | Alternate home-network PHY path select |
| done | output | 1 | Sequence finished, mode bits final |

## Verification
The bench builds the block with `HALF_CLKS = 2` and `POLL_CLKS = 2000`. With these values a frame takes about 260 clocks, so the timeout expires after a handful of polls. That puts every alternate-path branch, including the register-24 wrap from 0x00FE to 0xF001, within a few thousand cycles. A two-clock half-period also lets a per-edge PHY model check each header bit, the turnaround ownership and the MDC phase length on every frame.

// File: rtl/media_sense_pkg.sv
package media_sense_pkg;

  localparam int          PREAMBLE_LEN = 34;
  localparam logic [4:0]  PHY_ADDR     = 5'd1;

  localparam logic [4:0]  REG_CTRL  = 5'd0;
  localparam logic [4:0]  REG_STAT  = 5'd1;
  localparam logic [4:0]  REG_ID    = 5'd3;
  localparam logic [4:0]  REG_CFG   = 5'd16;
  localparam logic [4:0]  REG_SPEC  = 5'd17;
  localparam logic [4:0]  REG_TUNEA = 5'd24;
  localparam logic [4:0]  REG_TUNEB = 5'd25;
  localparam logic [4:0]  REG_VARID = 5'd31;

  localparam logic [15:0] LINK_MASK   = 16'h0024;
  localparam logic [15:0] DUPLEX_MASK = 16'hA000;
  localparam logic [15:0] ID_MASK     = 16'hFFF0;
  localparam logic [15:0] ID_FAMILY   = 16'hB900;
  localparam logic [15:0] ID_LATE_REV = 16'hB901;
  localparam logic [15:0] VAR_SIG     = 16'h4404;
  localparam logic [15:0] CFG_SHORT   = 16'h0005;
  localparam logic [15:0] CFG_LONG    = 16'h1005;

  typedef struct packed {
    logic        wr;
    logic [4:0]  reg_addr;
    logic [15:0] wdata;
  } mdio_cmd_t;

  typedef enum logic [3:0] {
    SQ_BOOT,
    SQ_FORCE,
    SQ_POLL,
    SQ_SPEC,
    SQ_ID,
    SQ_VAR,
    SQ_CFG,
    SQ_TUNE_RD,
    SQ_TUNE_WR,
    SQ_DONE
  } seq_state_e;

endpackage

// File: rtl/mdc_clock_gen.sv
module mdc_clock_gen #(
  parameter int HALF_CLKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_end
);
  localparam int CNT_W = $clog2(HALF_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CLKS - 1);

  logic [CNT_W-1:0] cnt;

  assign half_end = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || half_end) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int LIMIT = 200_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] END_VAL = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt;

  assign expired = (cnt == END_VAL);

  always_ff @(posedge clk) begin
    if (!rst_n || clear)    cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import media_sense_pkg::*;
#(
  parameter int HALF_CLKS = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  mdio_cmd_t   cmd,
  output logic        resp_valid,
  output logic [15:0] resp_data,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int HDR_SLOTS = PREAMBLE_LEN + 14;
  localparam int RD_SLOTS  = HDR_SLOTS + 17;
  localparam int WR_SLOTS  = HDR_SLOTS + 18;
  localparam int IDX_W     = $clog2(WR_SLOTS + 1);

  logic                busy;
  logic                phase;
  logic                is_wr;
  logic [WR_SLOTS-1:0] frame_q;
  logic [IDX_W-1:0]    idx;
  logic [15:0]         rd_sh;
  logic                half_end;
  logic                last_slot;

  mdc_clock_gen #(.HALF_CLKS(HALF_CLKS)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .half_end (half_end)
  );

  assign last_slot = (idx == (is_wr ? IDX_W'(WR_SLOTS - 1) : IDX_W'(RD_SLOTS - 1)));
  assign cmd_ready = !busy;
  assign resp_data = rd_sh;
  assign mdc       = busy && phase;
  assign mdio_oe   = busy && (is_wr || (idx < IDX_W'(HDR_SLOTS)));
  assign mdio_o    = mdio_oe && frame_q[WR_SLOTS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      phase      <= 1'b0;
      is_wr      <= 1'b0;
      frame_q    <= '0;
      idx        <= '0;
      rd_sh      <= '0;
      resp_valid <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      if (cmd_valid && cmd_ready) begin
        busy    <= 1'b1;
        phase   <= 1'b0;
        idx     <= '0;
        is_wr   <= cmd.wr;
        frame_q <= {{PREAMBLE_LEN{1'b1}}, 2'b01, (cmd.wr ? 2'b01 : 2'b10),
                    PHY_ADDR, cmd.reg_addr, 2'b10, cmd.wdata};
      end else if (busy && half_end) begin
        if (!phase) begin
          phase <= 1'b1;
          if (!is_wr && (idx > IDX_W'(HDR_SLOTS)))
            rd_sh <= {rd_sh[14:0], mdio_i};
        end else begin
          phase <= 1'b0;
          if (last_slot) begin
            busy       <= 1'b0;
            resp_valid <= 1'b1;
          end else begin
            idx     <= idx + 1'b1;
            frame_q <= {frame_q[WR_SLOTS-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/media_sense_ctrl.sv
module media_sense_ctrl
  import media_sense_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fixed_10m,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output mdio_cmd_t   cmd,
  input  logic        resp_valid,
  input  logic [15:0] resp_data,
  input  logic        tmo_expired,
  output logic        tmo_clear,
  output logic        tmo_run,
  output logic        store_fwd,
  output logic        full_duplex,
  output logic        alt_path,
  output logic        done
);
  seq_state_e  state;
  logic        pend;
  logic        var_hit;
  logic [15:0] id_q;
  logic [15:0] cfg_val;
  logic [15:0] tune_val;

  assign tmo_clear = (state == SQ_BOOT);
  assign tmo_run   = (state == SQ_POLL);
  assign cmd_valid = !pend && (state != SQ_BOOT) && (state != SQ_DONE);

  always_comb begin
    cmd = '0;
    case (state)
      SQ_FORCE:   begin cmd.wr = 1'b1; cmd.reg_addr = REG_CTRL; cmd.wdata = 16'h0000; end
      SQ_POLL:    cmd.reg_addr = REG_STAT;
      SQ_SPEC:    cmd.reg_addr = REG_SPEC;
      SQ_ID:      cmd.reg_addr = REG_ID;
      SQ_VAR:     cmd.reg_addr = REG_VARID;
      SQ_CFG:     begin cmd.wr = 1'b1; cmd.reg_addr = REG_CFG; cmd.wdata = cfg_val; end
      SQ_TUNE_RD: cmd.reg_addr = var_hit ? REG_TUNEA : REG_TUNEB;
      SQ_TUNE_WR: begin cmd.wr = 1'b1; cmd.reg_addr = REG_TUNEB; cmd.wdata = tune_val; end
      default:    cmd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= SQ_BOOT;
      pend        <= 1'b0;
      var_hit     <= 1'b0;
      id_q        <= '0;
      cfg_val     <= '0;
      tune_val    <= '0;
      store_fwd   <= 1'b0;
      full_duplex <= 1'b0;
      alt_path    <= 1'b0;
      done        <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) pend <= 1'b1;
      case (state)
        SQ_BOOT: begin
          store_fwd <= 1'b1;
          state     <= fixed_10m ? SQ_FORCE : SQ_POLL;
        end
        SQ_DONE: done <= 1'b1;
        default: begin
          if (resp_valid) begin
            pend <= 1'b0;
            case (state)
              SQ_FORCE: state <= SQ_DONE;
              SQ_POLL: begin
                if ((resp_data & LINK_MASK) == LINK_MASK) begin
                  state <= SQ_SPEC;
                end else if (tmo_expired) begin
                  alt_path <= 1'b1;
                  state    <= SQ_ID;
                end
              end
              SQ_SPEC: begin
                full_duplex <= |(resp_data & DUPLEX_MASK);
                state       <= SQ_DONE;
              end
              SQ_ID: begin
                id_q  <= resp_data;
                state <= ((resp_data & ID_MASK) == ID_FAMILY) ? SQ_VAR : SQ_DONE;
              end
              SQ_VAR: begin
                var_hit <= (resp_data == VAR_SIG);
                cfg_val <= ((resp_data == VAR_SIG) && (id_q != ID_LATE_REV)) ? CFG_LONG : CFG_SHORT;
                state   <= SQ_CFG;
              end
              SQ_CFG: state <= SQ_TUNE_RD;
              SQ_TUNE_RD: begin
                tune_val <= var_hit ? (((resp_data + 16'd3) & 16'h00FF) | 16'hF000)
                                    : ((resp_data & 16'hFF00) + 16'd2);
                state    <= SQ_TUNE_WR;
              end
              SQ_TUNE_WR: state <= SQ_DONE;
              default:    state <= SQ_DONE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/media_sense_seq.sv
module media_sense_seq
  import media_sense_pkg::*;
#(
  parameter int HALF_CLKS = 20,
  parameter int POLL_CLKS = 200_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fixed_10m,
  input  logic mdio_i,
  output logic mdc,
  output logic mdio_o,
  output logic mdio_oe,
  output logic store_fwd,
  output logic full_duplex,
  output logic alt_path,
  output logic done
);
  mdio_cmd_t   cmd;
  logic        cmd_valid;
  logic        cmd_ready;
  logic        resp_valid;
  logic [15:0] resp_data;
  logic        tmo_expired;
  logic        tmo_clear;
  logic        tmo_run;

  poll_timer #(.LIMIT(POLL_CLKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tmo_clear),
    .run     (tmo_run),
    .expired (tmo_expired)
  );

  mdio_frame_master #(.HALF_CLKS(HALF_CLKS)) u_mdio (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd        (cmd),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .mdio_i     (mdio_i),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );

  media_sense_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fixed_10m   (fixed_10m),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd         (cmd),
    .resp_valid  (resp_valid),
    .resp_data   (resp_data),
    .tmo_expired (tmo_expired),
    .tmo_clear   (tmo_clear),
    .tmo_run     (tmo_run),
    .store_fwd   (store_fwd),
    .full_duplex (full_duplex),
    .alt_path    (alt_path),
    .done        (done)
  );
endmodule

// File: rtl/media_sense_checker.sv
module media_sense_checker (
  input logic clk,
  input logic rst_n,
  input logic fixed_10m,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic store_fwd,
  input logic full_duplex,
  input logic alt_path,
  input logic done
);
  AST_SF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    store_fwd |=> store_fwd); // R1

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mdc) && mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R2

  AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_duplex && alt_path)); // R8

  AST_VARIANT_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_10m |-> (!full_duplex && !alt_path)); // R12

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R13

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mdc && !mdio_oe)); // R13

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(full_duplex) && $stable(alt_path))); // R13
endmodule

bind media_sense_seq media_sense_checker i_chk (.*);

// File: tb/test_media_sense_seq.sv
module test_media_sense_seq;
  localparam int HALF = 2;
  localparam int POLL = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fixed_10m = 1'b0;
  logic mdio_i = 1'b0;
  logic mdc, mdio_o, mdio_oe, store_fwd, full_duplex, alt_path, done;

  int total = 0;
  int bad = 0;

  // PHY model state
  logic [15:0] phy_regs [32];
  int          link_after;
  int          slot, rd1_count, rd_total, wr_count, frames;
  int          err_frame, err_ta_rd, err_ta_wr, err_period, hi_run;
  logic [47:0] hdr;
  logic        is_rd;
  logic [4:0]  cur_reg;
  logic [15:0] rd_val, wdat;

  always #2 clk = ~clk;

  media_sense_seq #(.HALF_CLKS(HALF), .POLL_CLKS(POLL)) i_media_sense_seq (
    .clk(clk), .rst_n(rst_n), .fixed_10m(fixed_10m), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .store_fwd(store_fwd),
    .full_duplex(full_duplex), .alt_path(alt_path), .done(done)
  );

  always @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      slot = 0; rd1_count = 0; rd_total = 0; wr_count = 0; frames = 0;
      err_frame = 0; err_ta_rd = 0; err_ta_wr = 0; hdr = '0; is_rd = 1'b0;
      cur_reg = '0; rd_val = '0; wdat = '0;
    end else begin
      if (slot < 48) begin
        if (!mdio_oe) err_frame++;
        hdr = {hdr[46:0], mdio_o};
        if (slot == 47) begin
          if (hdr[47:14] != {34{1'b1}} || hdr[13:12] != 2'b01 || hdr[9:5] != 5'd1) err_frame++;
          cur_reg = hdr[4:0];
          if (hdr[11:10] == 2'b10) begin
            is_rd = 1'b1;
            rd_total++;
            if (cur_reg == 5'd1) begin
              rd_val = (rd1_count >= link_after) ? 16'h002D : 16'h0004;
              rd1_count++;
            end else begin
              rd_val = phy_regs[cur_reg];
            end
          end else begin
            is_rd = 1'b0;
            if (hdr[11:10] != 2'b01) err_frame++;
          end
        end
      end else if (is_rd) begin
        if (mdio_oe) err_ta_rd++;
      end else begin
        if (!mdio_oe) err_ta_wr++;
        if (slot == 48 && mdio_o !== 1'b1) err_ta_wr++;
        if (slot == 49 && mdio_o !== 1'b0) err_ta_wr++;
        if (slot >= 50) wdat = {wdat[14:0], mdio_o};
      end
      if (is_rd && slot >= 48 && slot <= 63) mdio_i <= #1 rd_val[63-slot];
      if ((is_rd && slot == 64) || (!is_rd && slot == 65)) begin
        if (!is_rd) begin
          phy_regs[cur_reg] = wdat;
          wr_count++;
        end
        frames++;
        slot = 0;
      end else begin
        slot++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      hi_run = 0; err_period = 0;
    end else if (mdc) begin
      hi_run++;
    end else begin
      if (hi_run != 0 && hi_run != HALF) err_period++;
      hi_run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic variant, input int link_n);
    @(negedge clk);
    rst_n = 1'b0;
    fixed_10m = variant;
    link_after = link_n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(output int cyc, output int alt_cyc);
    cyc = 0;
    alt_cyc = -1;
    while (!done && cyc < 30000) begin
      @(negedge clk);
      cyc++;
      if (alt_path && alt_cyc < 0) alt_cyc = cyc;
    end
  endtask

  task automatic chk_bus();
    int f0;
    chk(err_frame == 0, "R2 header", err_frame, 0);
    chk(err_period == 0, "R3 mdc phase", err_period, 0);
    chk(err_ta_rd == 0, "R4 read turnaround", err_ta_rd, 0);
    chk(err_ta_wr == 0, "R5 write turnaround", err_ta_wr, 0);
    f0 = frames;
    repeat (400) @(negedge clk);
    chk(frames == f0 && done, "R13 quiet after done", frames, f0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fixed_10m = 1'b0;
    link_after = 0;
    repeat (2) @(negedge clk);
    chk({store_fwd, full_duplex, alt_path, done} == 4'b0000, "R1 in reset",
        {store_fwd, full_duplex, alt_path, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(store_fwd == 1'b1, "R1 sf after reset", store_fwd, 1);
    chk(done == 1'b0, "R1 done low", done, 0);
  endtask

  task automatic t_link(input int link_n, input logic [15:0] spec, input logic exp_full);
    int cyc, ac;
    phy_regs[17] = spec;
    do_reset(1'b0, link_n);
    wait_done(cyc, ac);
    chk(done, "R13 done", done, 1);
    chk(rd1_count == link_n + 1, "R6 poll count", rd1_count, link_n + 1);
    chk(full_duplex == exp_full, "R7 duplex", full_duplex, exp_full);
    chk(alt_path == 1'b0, "R7 no alt", alt_path, 0);
    chk(wr_count == 0, "R7 no writes", wr_count, 0);
    chk(store_fwd == 1'b1, "R1 sf held", store_fwd, 1);
    chk_bus();
  endtask

  task automatic t_alt(input logic [15:0] id, input logic [15:0] var_id,
                       input logic [15:0] r24, input logic [15:0] r25,
                       input logic exp_prog, input logic [15:0] exp16, input logic [15:0] exp25,
                       input string tag);
    int cyc, ac;
    phy_regs[3] = id; phy_regs[31] = var_id; phy_regs[24] = r24; phy_regs[25] = r25;
    phy_regs[16] = 16'hDEAD;
    do_reset(1'b0, 1000000);
    wait_done(cyc, ac);
    chk(done, "R13 done", done, 1);
    chk(alt_path == 1'b1 && full_duplex == 1'b0, "R8 alt selected", {alt_path, full_duplex}, 2'b10);
    chk(ac >= POLL, "R8 timeout honoured", ac, POLL);
    chk(rd1_count >= 2, "R6 repeated polls", rd1_count, 2);
    if (!exp_prog) begin
      chk(wr_count == 0, "R9 no writes", wr_count, 0);
      chk(phy_regs[16] == 16'hDEAD && phy_regs[25] == r25, "R9 regs untouched", phy_regs[25], r25);
    end else begin
      chk(wr_count == 2, {tag, " write count"}, wr_count, 2);
      chk(phy_regs[16] == exp16, {tag, " reg16"}, phy_regs[16], exp16);
      chk(phy_regs[25] == exp25, {tag, " reg25"}, phy_regs[25], exp25);
    end
    chk_bus();
  endtask

  task automatic t_variant();
    int cyc, ac;
    phy_regs[0] = 16'h3100;
    do_reset(1'b1, 0);
    wait_done(cyc, ac);
    chk(done, "R13 done", done, 1);
    chk(rd_total == 0, "R12 no reads", rd_total, 0);
    chk(wr_count == 1 && phy_regs[0] == 16'h0000, "R12 reg0 forced", phy_regs[0], 0);
    chk(!full_duplex && !alt_path, "R12 mode bits", {full_duplex, alt_path}, 0);
    chk_bus();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'h0000;
    link_after = 0;
    t_reset();
    t_link(2, 16'h8000, 1'b1);   // R6 R7: link after two partial reads
    t_link(0, 16'h2000, 1'b1);   // R7: other duplex bit
    t_link(1, 16'h5FFF, 1'b0);   // R7: half duplex
    t_alt(16'h1234, 16'h4404, 16'h0000, 16'h7777, 1'b0, 16'h0, 16'h0, "R9");
    t_alt(16'hB901, 16'h4404, 16'h00FE, 16'h0000, 1'b1, 16'h0005, 16'hF001, "R10");
    t_alt(16'hB905, 16'h4404, 16'h0010, 16'h0000, 1'b1, 16'h1005, 16'hF013, "R10");
    t_alt(16'hB900, 16'h1111, 16'h0000, 16'hABCD, 1'b1, 16'h0005, 16'hAB02, "R11");
    t_variant();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule